// File: doc/BRIEF.md
# Charge Pump Fastlock Timer Controller

This block decides which charge pump current code a frequency synthesizer's digital control section drives. Two current codes are supplied: a primary code for steady operation and a secondary, stronger code for the period after a new frequency is programmed. The block also receives the decoded configuration fields: an enable bit for the boost feature, a mode select bit and a 4-bit timeout code. It tracks the gain request bit that arrives with every divider latch write, and it uses a phase-detector cycle tick as its time base.

The boost can end in one of two ways. With the mode select bit at 0, it lasts until software writes the gain request bit back to 0. With the mode select bit at 1, an internal timer counts phase-detector ticks after the request. When the programmed count is reached, the timer clears the stored gain bit by itself and the output falls back to the primary code. The block is then ready for the next frequency change. A power-down or counter reset input returns the timer to its load state.

Top module: `fastlock_ctrl`

## Requirements
- R1: After reset the stored gain bit reads 0, the boost indicator is 0 and the current code equals the primary code.
- R2: While the boost enable input is 0, the current code equals the primary code whatever the stored gain bit, and the stored gain bit still follows divider writes.
- R3: A divider write stores its gain value at the capturing clock edge. With enable at 1 and the stored gain at 1, the current code equals the secondary code and the boost indicator is 1.
- R4: With mode select 0, a stored gain of 1 is kept through any number of ticks and clears only when a divider write carries gain 0.
- R5: With mode select 1, the timeout is 4*code+3 ticks counted from the write. The gain bit stays 1 through tick number 4*code+2 and clears at the edge of tick number 4*code+3. Clock edges without a tick do not advance the count.
- R6: After a timed expiry the stored gain bit reads 0 and the current code is primary. A new write of gain 1 starts a complete fresh timeout.
- R7: A divider write of gain 1 while the timer is running restarts the full timeout from that write.
- R8: An edge with the hold input (power-down or counter reset) high returns the timer to its load state without changing the stored gain bit. The full timeout then counts from the following ticks.
- R9: A divider write on the same edge as the expiring tick takes priority. The gain bit takes the written value, and a written 1 starts a new timeout.
- R10: The timeout range covers code 0 (3 ticks) through code 15 (63 ticks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_boost_en | input | 1 | Boost feature enable from the function latch |
| cfg_timed_mode | input | 1 | 0: software exit, 1: timer exit |
| cfg_tmo_code | input | 4 | Timeout code, timeout = 4*code+3 ticks |
| cur_primary | input | 3 | Current code for steady operation |
| cur_secondary | input | 3 | Current code during boost |
| div_wr | input | 1 | One-cycle strobe: divider latch written |
| div_wr_gain | input | 1 | Gain request bit carried by the divider write |
| pd_tick | input | 1 | One pulse per phase-detector cycle |
| hold_load | input | 1 | Power-down or counter reset: force timer to load state |
| cp_code | output | 3 | Selected charge pump current code |
| gain_bit | output | 1 | Stored gain request bit |
| boost_active | output | 1 | High while the secondary code is selected |

## Verification
The bench checks the exact tick on which the timed boost ends, at the smallest and largest codes and at a middle code. An off-by-one in the load value or in the terminal compare shows up as the primary code returning one tick early or late. It also rewrites the gain bit in the middle of a timeout and on the expiring tick itself. A design that failed to reload, or that let the hardware clear win over the write, would drop back to the primary code too soon. The hold input is exercised partway through a count, and software-exit mode is held across many ticks. This catches a timer that leaks into mode 0 or a hold that disturbs the stored gain bit.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int unsigned CODE_W_DEF = 4;
  localparam int unsigned CUR_W_DEF  = 3;
endpackage

// File: rtl/fl_gain_reg.sv
module fl_gain_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_val,
  input  logic hw_clr,
  output logic gain_q
);
  logic gain_en;
  logic gain_nxt;

  // software write wins over the timer's clear
  always_comb begin
    gain_en  = wr | hw_clr;
    gain_nxt = wr ? wr_val : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain_q <= 1'b0;
    else if (gain_en) gain_q <= gain_nxt;
  end
endmodule

// File: rtl/fl_timer.sv
module fl_timer #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              reload,
  input  logic              hold,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              expire
);
  localparam int unsigned CNT_W = CODE_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] load_val;
  logic             force_load;
  logic             cnt_en;

  always_comb begin
    load_val   = {code, 2'b11};  // 4*code+3
    force_load = !run || hold || reload;
    cnt_en     = force_load || tick;
    if (force_load) cnt_nxt = load_val;
    else            cnt_nxt = cnt_q - 1'b1;
    expire = run && tick && !hold && !reload &&
             (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/fl_cur_sel.sv
module fl_cur_sel #(
  parameter int unsigned CUR_W = 3
) (
  input  logic             boost_en,
  input  logic             gain,
  input  logic [CUR_W-1:0] cur_pri,
  input  logic [CUR_W-1:0] cur_sec,
  output logic [CUR_W-1:0] code,
  output logic             active
);
  assign active = boost_en & gain;

  for (genvar b = 0; b < CUR_W; b++) begin : g_bit
    assign code[b] = active ? cur_sec[b] : cur_pri[b];
  end
endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl #(
  parameter int unsigned CODE_W = fl_pkg::CODE_W_DEF,
  parameter int unsigned CUR_W  = fl_pkg::CUR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_boost_en,
  input  logic              cfg_timed_mode,
  input  logic [CODE_W-1:0] cfg_tmo_code,
  input  logic [CUR_W-1:0]  cur_primary,
  input  logic [CUR_W-1:0]  cur_secondary,
  input  logic              div_wr,
  input  logic              div_wr_gain,
  input  logic              pd_tick,
  input  logic              hold_load,
  output logic [CUR_W-1:0]  cp_code,
  output logic              gain_bit,
  output logic              boost_active
);
  logic gain_q;
  logic tmr_run;
  logic tmr_reload;
  logic tmr_expire;

  assign tmr_run    = gain_q & cfg_boost_en & cfg_timed_mode;
  assign tmr_reload = div_wr & div_wr_gain;

  fl_gain_reg u_gain (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (div_wr),
    .wr_val (div_wr_gain),
    .hw_clr (tmr_expire),
    .gain_q (gain_q)
  );

  fl_timer #(.CODE_W(CODE_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (tmr_run),
    .reload (tmr_reload),
    .hold   (hold_load),
    .tick   (pd_tick),
    .code   (cfg_tmo_code),
    .expire (tmr_expire)
  );

  fl_cur_sel #(.CUR_W(CUR_W)) u_sel (
    .boost_en (cfg_boost_en),
    .gain     (gain_q),
    .cur_pri  (cur_primary),
    .cur_sec  (cur_secondary),
    .code     (cp_code),
    .active   (boost_active)
  );

  assign gain_bit = gain_q;
endmodule

// File: rtl/fastlock_ctrl_chk.sv
module fastlock_ctrl_chk #(
  parameter int unsigned CUR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_boost_en,
  input logic             cfg_timed_mode,
  input logic [CUR_W-1:0] cur_primary,
  input logic [CUR_W-1:0] cur_secondary,
  input logic             div_wr,
  input logic             div_wr_gain,
  input logic             pd_tick,
  input logic             hold_load,
  input logic [CUR_W-1:0] cp_code,
  input logic             gain_bit,
  input logic             boost_active
);
  p_disabled_primary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_boost_en |-> (cp_code == cur_primary && !boost_active));

  p_boost_secondary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_boost_en && gain_bit) |-> (cp_code == cur_secondary));

  p_write_stores_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (gain_bit == $past(div_wr_gain)));

  p_soft_exit_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_bit && !(cfg_boost_en && cfg_timed_mode) && !div_wr) |=> gain_bit);

  p_no_tick_no_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_bit && !div_wr && !pd_tick) |=> gain_bit);

  p_hold_keeps_gain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_load && !div_wr) |=> $stable(gain_bit));
endmodule

bind fastlock_ctrl fastlock_ctrl_chk #(.CUR_W(CUR_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_boost_en   (cfg_boost_en),
  .cfg_timed_mode (cfg_timed_mode),
  .cur_primary    (cur_primary),
  .cur_secondary  (cur_secondary),
  .div_wr         (div_wr),
  .div_wr_gain    (div_wr_gain),
  .pd_tick        (pd_tick),
  .hold_load      (hold_load),
  .cp_code        (cp_code),
  .gain_bit       (gain_bit),
  .boost_active   (boost_active)
);

// File: tb/fastlock_ctrl_tb_top.sv
`timescale 1ns/1ps
module fastlock_ctrl_tb_top;
  localparam logic [2:0] PRI = 3'b010;
  localparam logic [2:0] SEC = 3'b101;

  logic       clk;
  logic       rst_n;
  logic       cfg_boost_en;
  logic       cfg_timed_mode;
  logic [3:0] cfg_tmo_code;
  logic [2:0] cur_primary;
  logic [2:0] cur_secondary;
  logic       div_wr;
  logic       div_wr_gain;
  logic       pd_tick;
  logic       hold_load;
  logic [2:0] cp_code;
  logic       gain_bit;
  logic       boost_active;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    int         due;
    logic       gain;
    logic [2:0] code;
    logic       act;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  fastlock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_boost_en(cfg_boost_en),
    .cfg_timed_mode(cfg_timed_mode), .cfg_tmo_code(cfg_tmo_code),
    .cur_primary(cur_primary), .cur_secondary(cur_secondary),
    .div_wr(div_wr), .div_wr_gain(div_wr_gain), .pd_tick(pd_tick),
    .hold_load(hold_load), .cp_code(cp_code), .gain_bit(gain_bit),
    .boost_active(boost_active)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare the head of the scoreboard when it falls due
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (gain_bit !== e.gain || cp_code !== e.code || boost_active !== e.act) begin
        errors++;
        $display("FAIL %s: got gain=%b code=%b act=%b, expected gain=%b code=%b act=%b",
                 e.tag, gain_bit, cp_code, boost_active, e.gain, e.code, e.act);
      end
    end
  end

  // driver: one strobe edge, then one quiet edge where the result is checked
  task automatic step(input logic wr, input logic wv, input logic tk, input logic hd,
                      input logic eg, input string tag);
    exp_t e;
    @(posedge clk); #1;
    div_wr = wr; div_wr_gain = wv; pd_tick = tk; hold_load = hd;
    e.due  = cyc + 1;
    e.gain = eg;
    e.act  = eg & cfg_boost_en;
    e.code = (eg & cfg_boost_en) ? cur_secondary : cur_primary;
    e.tag  = tag;
    sb_q.push_back(e);
    @(posedge clk); #1;
    div_wr = 0; div_wr_gain = 0; pd_tick = 0; hold_load = 0;
    @(negedge clk); #1;
  endtask

  task automatic ticks(input int n, input logic eg, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, eg, tag);
  endtask

  // write gain 1, then check the exact expiry tick for load value L
  task automatic timed_run(input int l, input string tag);
    step(1, 1, 0, 0, 1, tag);
    ticks(l - 1, 1, tag);
    ticks(1, 0, tag);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_boost_en = 0; cfg_timed_mode = 0; cfg_tmo_code = 0;
    cur_primary = PRI; cur_secondary = SEC;
    div_wr = 0; div_wr_gain = 0; pd_tick = 0; hold_load = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;

    // R1 reset state
    step(0, 0, 0, 0, 0, "R1 reset");

    // R2 boost disabled: gain stored but primary used
    step(1, 1, 0, 0, 1, "R2 disabled gain write");
    ticks(5, 1, "R2 disabled ticks");
    step(1, 0, 0, 0, 0, "R2 disabled clear");

    // R3 / R4 software-exit mode
    cfg_boost_en = 1; cfg_timed_mode = 0; cfg_tmo_code = 0;
    step(1, 1, 0, 0, 1, "R3 write selects secondary");
    ticks(20, 1, "R4 no timer in mode 0");
    step(1, 0, 0, 0, 0, "R4 software clear");

    // R5 / R10 timed mode, code 0 -> 3 ticks
    cfg_timed_mode = 1; cfg_tmo_code = 4'd0;
    timed_run(3, "R10 code0 timeout");
    // R5 idle edges do not count
    cfg_tmo_code = 4'd2;
    step(1, 1, 0, 0, 1, "R5 start code2");
    ticks(5, 1, "R5 count");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, "R5 idle edge");
    ticks(5, 1, "R5 count");
    ticks(1, 0, "R5 expiry at 11");
    // R6 fresh timeout after expiry
    timed_run(11, "R6 restart after expiry");

    // R7 rewrite while running
    cfg_tmo_code = 4'd1;
    step(1, 1, 0, 0, 1, "R7 start");
    ticks(5, 1, "R7 partial");
    step(1, 1, 0, 0, 1, "R7 rewrite");
    ticks(6, 1, "R7 full again");
    ticks(1, 0, "R7 expiry");

    // R8 hold reloads timer
    step(1, 1, 0, 0, 1, "R8 start");
    ticks(5, 1, "R8 partial");
    step(0, 0, 0, 1, 1, "R8 hold keeps gain");
    ticks(6, 1, "R8 reloaded");
    ticks(1, 0, "R8 expiry");

    // R9 write on the expiring tick
    cfg_tmo_code = 4'd0;
    step(1, 1, 0, 0, 1, "R9 start");
    ticks(2, 1, "R9 partial");
    step(1, 1, 1, 0, 1, "R9 write wins over expiry");
    ticks(2, 1, "R9 new timeout");
    ticks(1, 0, "R9 new expiry");
    step(1, 1, 0, 0, 1, "R9 start2");
    ticks(2, 1, "R9 partial2");
    step(1, 0, 1, 0, 0, "R9 write zero on expiry");

    // R10 largest code -> 63 ticks
    cfg_tmo_code = 4'd15;
    timed_run(63, "R10 code15 timeout");

    repeat (3) @(posedge clk);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending, expected 0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule